// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block is the digital comparison stage of a frequency synthesizer loop. It watches two single-cycle strobes, one from the divided reference and one from the divided feedback path, all sampled on the system clock. A strobe arms a flag for its side, and the flag stays set until the other side's strobe arrives. Once both flags are set they are cleared together one cycle later. Phase and frequency errors of up to a full cycle either way are thus turned into a width-modulated pump-up or pump-down request. Matched edges still give a one-cycle pulse on both outputs, and this keeps the pump out of a dead zone.

A polarity input selects which flag drives the up request and which drives the down request, for loops whose oscillator tunes in the opposite direction. The same selection chooses which divider strobe appears on the monitor output. A second output pair is provided for driving a discrete pump: an active-low up and an active-high down. The lock flag drops while only one side is armed, which is the part of a correction pulse longer than the overlap. A sleep request is honoured only once both flags are idle, so that the loop is never left with a half-finished correction.

Top module: `pfd_lock`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, up_o=0, dn_o=0, ext_up_n=1, ext_dn=0, lock_o=1 and sleep_o=0.
- R2: With pol_hi=1, a ref_stb pulse sets up_o from the next cycle, and an fb_stb pulse sets dn_o from the next cycle. A side that is already armed is unaffected by further strobes on that side, and it holds until the opposite strobe comes.
- R3: In a cycle where both flags are set, both are cleared at the next edge, and strobes sampled in that cycle are dropped. Strobes that coincide give exactly one cycle on up_o and dn_o together.
- R4: With pol_hi=0, the reference flag drives dn_o and the feedback flag drives up_o. The swap takes effect in the same cycle pol_hi changes.
- R5: ext_up_n is always the inverse of up_o, and ext_dn always equals dn_o, so the external pair follows the polarity swap.
- R6: mon_o equals ref_stb when pol_hi=1 and fb_stb when pol_hi=0, with no register delay.
- R7: lock_o is 0 in exactly those cycles where one of up_o and dn_o is 1 and the other is 0. It is 1 when both or neither are set.
- R8: If sleep_req=1 in a cycle where up_o and dn_o are both 0, sleep_o is 1 from the next cycle. While either output is active, sleep_o stays 0 and detection continues.
- R9: While sleep_o=1, up_o and dn_o are 0 and strobes are ignored. If sleep_req=0 in such a cycle, sleep_o returns to 0 at the next edge with both flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_stb | input | 1 | One-cycle strobe from the reference divider |
| fb_stb | input | 1 | One-cycle strobe from the feedback divider |
| pol_hi | input | 1 | 1: normal polarity, 0: swapped |
| sleep_req | input | 1 | Power-down request |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| ext_up_n | output | 1 | External pump up, active low |
| ext_dn | output | 1 | External pump down, active high |
| lock_o | output | 1 | Lock flag, low during unmatched correction |
| mon_o | output | 1 | Monitor of the selected divider strobe |
| sleep_o | output | 1 | Powered-down status |

## Verification
The hardest case to reach is a sleep request that arrives while one flag is armed and the opposite strobe is late, because only then is entry into power-down visibly deferred. The case gets harder when that strobe lands in the overlap cycle and is dropped. Directed sequences arm one side, raise the request, hold back the other strobe for several cycles and then release it. Random traffic with sleep bursts and occasional polarity flips covers the remaining interleavings, and each cycle is compared against a bench model.

// File: rtl/pfd_lock.sv
module pfd_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_stb,
  input  logic fb_stb,
  input  logic pol_hi,
  input  logic sleep_req,
  output logic up_o,
  output logic dn_o,
  output logic ext_up_n,
  output logic ext_dn,
  output logic lock_o,
  output logic mon_o,
  output logic sleep_o
);
  logic ref_q, fb_q, pd_q;
  logic idle;

  assign idle = !ref_q && !fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
      pd_q  <= 1'b0;
    end else if (pd_q) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
      pd_q  <= sleep_req;
    end else if (sleep_req && idle) begin
      pd_q  <= 1'b1;
    end else if (ref_q && fb_q) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_q | ref_stb;
      fb_q  <= fb_q | fb_stb;
    end
  end

  assign up_o     = pol_hi ? ref_q : fb_q;
  assign dn_o     = pol_hi ? fb_q : ref_q;
  assign ext_up_n = ~up_o;
  assign ext_dn   = dn_o;
  assign lock_o   = ~(ref_q ^ fb_q);
  assign mon_o    = pol_hi ? ref_stb : fb_stb;
  assign sleep_o  = pd_q;
endmodule

module pfd_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic up_o,
  input logic dn_o,
  input logic lock_o,
  input logic sleep_o
);
  // R3
  overlap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && dn_o) |=> (!up_o && !dn_o));
  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(!up_o && !dn_o));
  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> (!up_o && !dn_o));
  // R9
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && !sleep_req) |=> !sleep_o);
  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> !$past(up_o && dn_o));
endmodule

bind pfd_lock pfd_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
  .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o), .sleep_o(sleep_o)
);

// File: tb/sim_pfd_lock.sv
module sim_pfd_lock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_stb = 1'b0, fb_stb = 1'b0, pol_hi = 1'b1, sleep_req = 1'b0;
  logic up_o, dn_o, ext_up_n, ext_dn, lock_o, mon_o, sleep_o;
  int runs = 0, fails = 0;
  bit mr = 1'b0, mf = 1'b0, mpd = 1'b0;

  always #2.5 clk = ~clk;

  pfd_lock u0 (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .pol_hi(pol_hi), .sleep_req(sleep_req), .up_o(up_o), .dn_o(dn_o),
    .ext_up_n(ext_up_n), .ext_dn(ext_dn), .lock_o(lock_o), .mon_o(mon_o),
    .sleep_o(sleep_o)
  );

  function automatic bit exp_up(bit r, bit f, bit p);
    return p ? r : f;
  endfunction
  function automatic bit exp_dn(bit r, bit f, bit p);
    return p ? f : r;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 R4 up_o", up_o, exp_up(mr, mf, pol_hi));
    chk("R2 R3 R4 dn_o", dn_o, exp_dn(mr, mf, pol_hi));
    chk("R5 ext_up_n", ext_up_n, ~exp_up(mr, mf, pol_hi));
    chk("R5 ext_dn", ext_dn, exp_dn(mr, mf, pol_hi));
    chk("R7 lock_o", lock_o, ~(mr ^ mf));
    chk("R6 mon_o", mon_o, pol_hi ? ref_stb : fb_stb);
    chk("R8 R9 sleep_o", sleep_o, mpd);
  endtask

  task automatic cyc(bit r, bit f, bit p, bit s);
    ref_stb = r; fb_stb = f; pol_hi = p; sleep_req = s;
    #1;
    check_all();
    @(posedge clk);
    if (mpd) begin
      mr = 0; mf = 0; mpd = s;
    end else if (s && !mr && !mf) begin
      mpd = 1;
    end else if (mr && mf) begin
      mr = 0; mf = 0;
    end else begin
      mr = mr | r; mf = mf | f;
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    bit p, s;
    void'($urandom(32'd20240611));
    #1;
    // R1 during reset
    chk("R1 up", up_o, 1'b0); chk("R1 dn", dn_o, 1'b0);
    chk("R1 ext_up_n", ext_up_n, 1'b1); chk("R1 ext_dn", ext_dn, 1'b0);
    chk("R1 lock", lock_o, 1'b1); chk("R1 sleep", sleep_o, 1'b0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 1, 0);
    // R3 coincident strobes: one-cycle overlap
    cyc(1, 1, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    // R2 reference leads by three, extra ref strobes absorbed
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0); cyc(0, 0, 1, 0); cyc(0, 1, 1, 0);
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    // R3 strobe in the overlap cycle is dropped
    cyc(0, 1, 1, 0); cyc(1, 0, 1, 0); cyc(1, 1, 1, 0); cyc(0, 0, 1, 0);
    // R4 R6 swapped polarity, feedback leads
    cyc(0, 1, 0, 0); cyc(0, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
    // R4 polarity flip while armed
    cyc(1, 0, 1, 0); cyc(0, 0, 0, 0); cyc(0, 1, 1, 0); cyc(0, 0, 1, 0);
    // R8 deferred entry: armed side, request held, late strobe
    cyc(1, 0, 1, 0); cyc(0, 0, 1, 1); cyc(0, 0, 1, 1); cyc(0, 0, 1, 1);
    cyc(0, 1, 1, 1); cyc(0, 0, 1, 1); cyc(0, 0, 1, 1);
    // R9 strobes ignored while asleep, then exit
    cyc(1, 0, 1, 1); cyc(0, 1, 0, 1); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    p = 1; s = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 50 == 0) p = ~p;
      if ($urandom % 40 == 0) s = ~s;
      cyc(($urandom % 4) == 0, ($urandom % 4) == 0, p, s);
    end
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule